// File: doc/BRIEF.md
# Coordinate-Driven Test Delay Generator

This block builds a self-test stimulus for a three-microphone time-difference localiser. It takes a source position on an integer grid and works out how many whole samples sound needs to reach each of three microphones. The microphones sit on a right-angle triangle at grid points (0,0), (16,0) and (0,16). Each delay is rounded to the nearest sample. The smallest of the three delays is then subtracted from all of them, so the earliest channel always has zero delay.

On every sample strobe the block emits one beat carrying three channel samples. In synthetic mode all three channels replay one waveform. The waveform is computed from the sample address, and each channel is shifted back by its own relative delay. In microphone mode the three live microphone samples pass straight through. A localiser downstream can therefore be exercised with no sensors attached, and the true answer is known.

The output is a valid/ready stream. A beat stays on the outputs, unchanged, until it is accepted. While a beat is waiting, sample strobes are dropped and the buffer position does not move. A new coordinate is taken in only at the first beat of a buffer, so every beat of a buffer uses the same set of delays.

Top module: `tdoa_stim_gen`

## Requirements
- R1: Absolute delay for microphone k is floor(dist*3/2 + 0.5). Here dist is the Euclidean grid distance from (src_x, src_y) to the microphone, and src_x and src_y are 6-bit two's complement. The microphones are at (0,0), (16,0) and (0,16). The delay saturates at 127.
- R2: Each relative delay output equals that channel's absolute delay minus the smallest of the three. While out_valid is high, at least one of rel_a, rel_b and rel_c is zero.
- R3: In synthetic mode (use_mic = 0) the beat at buffer position b carries, on channel k, W(b - rel_k). W(a) is the low 8 bits of a*37+11. A channel gives 0 when b < rel_k.
- R4: In microphone mode (use_mic = 1), ch_a, ch_b and ch_c equal mic_a, mic_b and mic_c as they were on the accepting clock edge.
- R5: Delays for a changed coordinate are applied only at a beat with buffer position 0, and only once the computation has finished (within 140 cycles). The rel outputs do not change at any other beat.
- R6: An accepted strobe is one where sample_stb = 1 and either out_valid = 0 or out_ready = 1. Each accepted strobe raises out_valid on the next cycle and advances the buffer position by one. The position runs from 0 to 127 and then wraps to 0.
- R7: While out_valid = 1 and out_ready = 0, all outputs hold. Sample strobes in that time are ignored and do not advance the buffer position.
- R8: After reset, out_valid is 0, all relative delays are 0 and the buffer position is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_x | input | 6 | Source x grid coordinate, signed |
| src_y | input | 6 | Source y grid coordinate, signed |
| use_mic | input | 1 | 0 selects the synthetic channels, 1 selects the live microphones |
| sample_stb | input | 1 | Sample-rate strobe that requests one beat |
| mic_a | input | 8 | Live microphone sample, channel a |
| mic_b | input | 8 | Live microphone sample, channel b |
| mic_c | input | 8 | Live microphone sample, channel c |
| out_ready | input | 1 | Downstream can accept the beat |
| out_valid | output | 1 | Beat present on the outputs |
| ch_a | output | 8 | Channel a sample |
| ch_b | output | 8 | Channel b sample |
| ch_c | output | 8 | Channel c sample |
| rel_a | output | 7 | Relative delay of channel a, in samples |
| rel_b | output | 7 | Relative delay of channel b, in samples |
| rel_c | output | 7 | Relative delay of channel c, in samples |

## Verification
The assertions assume that no coordinate change arrives within 140 cycles of a buffer start that is meant to use it. They also assume that sample_stb and out_ready are driven only from reset onward, and that the hold check relies on out_ready staying low only while a beat is pending. The stimulus sets each coordinate and then waits 200 cycles before it steps beats towards the next buffer start. It drives strobes and ready at the falling edge. It uses random coordinates across the full signed range, together with microphone-adjacent, diagonal and extreme corner points. It also applies deliberate stalls with extra strobes during the stall.

// File: rtl/tdoa_stim_pkg.sv
package tdoa_stim_pkg;
  localparam int NCH = 3;
  // right-angle triangle of sensors, grid units
  localparam int MIC_X [NCH] = '{0, 16, 0};
  localparam int MIC_Y [NCH] = '{0, 0, 16};

  // synthetic test waveform, computed from the address instead of stored
  function automatic logic [31:0] wave_word(input logic [31:0] addr);
    return addr * 32'd37 + 32'd11;
  endfunction
endpackage

// File: rtl/tdoa_range_calc.sv
module tdoa_range_calc #(
  parameter int CW  = 6,
  parameter int AW  = 7,
  parameter int NUM = 3,
  parameter int DEN = 2,
  parameter int MX  = 0,
  parameter int MY  = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic signed [CW-1:0] px,
  input  logic signed [CW-1:0] py,
  output logic                 busy,
  output logic [AW-1:0]        dly
);
  localparam logic [AW-1:0] MAXD = {AW{1'b1}};

  logic [AW-1:0] n;
  logic          hit;
  longint        dxl, dyl, d2, odd;

  // rounded sqrt by search: smallest n with (2n+1)^2*DEN^2 > 4*d2*NUM^2
  always_comb begin
    dxl = longint'(px) - longint'(MX);
    dyl = longint'(py) - longint'(MY);
    d2  = dxl * dxl + dyl * dyl;
    odd = 2 * longint'(n) + 1;
    hit = (odd * odd * longint'(DEN) * longint'(DEN)) >
          (4 * d2 * longint'(NUM) * longint'(NUM));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      n    <= '0;
      dly  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      n    <= '0;
    end else if (busy) begin
      if (hit || n == MAXD) begin
        busy <= 1'b0;
        dly  <= n;
      end else begin
        n <= n + 1'b1;
      end
    end
  end

  // R1: a search that ends on a hit must not have passed an earlier hit
  p_search_ends_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start && $past(busy) && !$past(start) && n != '0) |-> !$past(hit));
endmodule

// File: rtl/tdoa_chan_tap.sv
module tdoa_chan_tap
  import tdoa_stim_pkg::*;
#(
  parameter int AW = 7,
  parameter int SW = 8
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] rel,
  output logic [SW-1:0] smp
);
  logic [31:0] w;
  logic [AW-1:0] addr;

  always_comb begin
    addr = base - rel;
    w    = wave_word(32'(addr));
    // reads before address zero give silence
    smp  = (base < rel) ? '0 : w[SW-1:0];
  end
endmodule

// File: rtl/tdoa_stim_gen.sv
module tdoa_stim_gen
  import tdoa_stim_pkg::*;
#(
  parameter int CW      = 6,
  parameter int SW      = 8,
  parameter int BUF_LEN = 128,
  parameter int DLY_NUM = 3,
  parameter int DLY_DEN = 2,
  parameter int AW      = $clog2(BUF_LEN)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [CW-1:0] src_x,
  input  logic signed [CW-1:0] src_y,
  input  logic                 use_mic,
  input  logic                 sample_stb,
  input  logic [SW-1:0]        mic_a,
  input  logic [SW-1:0]        mic_b,
  input  logic [SW-1:0]        mic_c,
  input  logic                 out_ready,
  output logic                 out_valid,
  output logic [SW-1:0]        ch_a,
  output logic [SW-1:0]        ch_b,
  output logic [SW-1:0]        ch_c,
  output logic [AW-1:0]        rel_a,
  output logic [AW-1:0]        rel_b,
  output logic [AW-1:0]        rel_c
);
  localparam logic [AW-1:0] LAST = AW'(BUF_LEN - 1);

  logic signed [CW-1:0] lat_x, lat_y;
  logic                 start;
  logic [NCH-1:0]       busy;
  logic [AW-1:0]        dly     [NCH];
  logic [AW-1:0]        new_rel [NCH];
  logic [AW-1:0]        use_rel [NCH];
  logic [AW-1:0]        act_rel [NCH];
  logic [SW-1:0]        tap_smp [NCH];
  logic [SW-1:0]        mic_in  [NCH];
  logic [SW-1:0]        ch_q    [NCH];
  logic [AW-1:0]        base, dmin;
  logic                 calc_ok, accept, commit;

  // restart the range search whenever the coordinate moves
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_x <= '0;
      lat_y <= '0;
      start <= 1'b1;
    end else begin
      lat_x <= src_x;
      lat_y <= src_y;
      start <= (src_x != lat_x) || (src_y != lat_y);
    end
  end

  assign mic_in[0] = mic_a;
  assign mic_in[1] = mic_b;
  assign mic_in[2] = mic_c;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    tdoa_range_calc #(
      .CW(CW), .AW(AW), .NUM(DLY_NUM), .DEN(DLY_DEN),
      .MX(MIC_X[k]), .MY(MIC_Y[k])
    ) u_range (
      .clk(clk), .rst_n(rst_n), .start(start),
      .px(lat_x), .py(lat_y), .busy(busy[k]), .dly(dly[k])
    );
    tdoa_chan_tap #(.AW(AW), .SW(SW)) u_tap (
      .base(base), .rel(use_rel[k]), .smp(tap_smp[k])
    );
  end

  always_comb begin
    dmin = dly[0];
    for (int k = 1; k < NCH; k++)
      if (dly[k] < dmin) dmin = dly[k];
    for (int k = 0; k < NCH; k++) begin
      new_rel[k] = dly[k] - dmin;
      use_rel[k] = commit ? new_rel[k] : act_rel[k];
    end
  end

  assign calc_ok = !start && (busy == '0);
  assign accept  = sample_stb && (!out_valid || out_ready);
  assign commit  = accept && (base == '0) && calc_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      base      <= '0;
      for (int k = 0; k < NCH; k++) begin
        act_rel[k] <= '0;
        ch_q[k]    <= '0;
      end
    end else if (accept) begin
      out_valid <= 1'b1;
      base      <= (base == LAST) ? '0 : base + 1'b1;
      for (int k = 0; k < NCH; k++) begin
        act_rel[k] <= use_rel[k];
        ch_q[k]    <= use_mic ? mic_in[k] : tap_smp[k];
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign ch_a  = ch_q[0];
  assign ch_b  = ch_q[1];
  assign ch_c  = ch_q[2];
  assign rel_a = act_rel[0];
  assign rel_b = act_rel[1];
  assign rel_c = act_rel[2];

  p_one_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (rel_a == '0 || rel_b == '0 || rel_c == '0));

  p_mid_buffer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(accept && base == '0) |-> ($stable(rel_a) && $stable(rel_b) && $stable(rel_c)));

  p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  p_mic_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && use_mic) |=> (ch_a == $past(mic_a) && ch_b == $past(mic_b) && ch_c == $past(mic_c)));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(ch_a) && $stable(ch_b)
                                   && $stable(ch_c) && $stable(rel_a)));
endmodule

// File: tb/test_tdoa_stim_gen.sv
module test_tdoa_stim_gen;
  localparam int CLK_PERIOD = 10;
  localparam int BUF = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [5:0] src_x = '0, src_y = '0;
  logic use_mic = 1'b0, sample_stb = 1'b0, out_ready = 1'b1;
  logic [7:0] mic_a = '0, mic_b = '0, mic_c = '0;
  logic out_valid;
  logic [7:0] ch_a, ch_b, ch_c;
  logic [6:0] rel_a, rel_b, rel_c;

  int checks = 0, errors = 0;
  int exp_base = 0;
  int exp_rel [3] = '{0, 0, 0};
  int cx = 0, cy = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdoa_stim_gen i_tdoa_stim_gen (
    .clk(clk), .rst_n(rst_n), .src_x(src_x), .src_y(src_y),
    .use_mic(use_mic), .sample_stb(sample_stb),
    .mic_a(mic_a), .mic_b(mic_b), .mic_c(mic_c),
    .out_ready(out_ready), .out_valid(out_valid),
    .ch_a(ch_a), .ch_b(ch_b), .ch_c(ch_c),
    .rel_a(rel_a), .rel_b(rel_b), .rel_c(rel_c)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int abs_dly(input int x, input int y, input int mx, input int my);
    real d;
    int v;
    d = $sqrt(real'((x - mx) * (x - mx) + (y - my) * (y - my)));
    v = int'($floor(d * 1.5 + 0.5));
    return (v > 127) ? 127 : v;
  endfunction

  function automatic int wave(input int a);
    return (a * 37 + 11) % 256;
  endfunction

  // R1/R2 model for the current coordinate
  task automatic load_rel();
    int d [3];
    int m;
    d[0] = abs_dly(cx, cy, 0, 0);
    d[1] = abs_dly(cx, cy, 16, 0);
    d[2] = abs_dly(cx, cy, 0, 16);
    m = d[0];
    for (int k = 1; k < 3; k++) if (d[k] < m) m = d[k];
    for (int k = 0; k < 3; k++) exp_rel[k] = d[k] - m;
  endtask

  task automatic set_coord(input int x, input int y);
    cx = x; cy = y;
    src_x = 6'(x); src_y = 6'(y);
    repeat (200) @(negedge clk);
  endtask

  task automatic beat_check();
    int e [3];
    logic [7:0] m [3];
    m[0] = 8'($urandom); m[1] = 8'($urandom); m[2] = 8'($urandom);
    mic_a = m[0]; mic_b = m[1]; mic_c = m[2];
    sample_stb = 1'b1;
    @(negedge clk);
    sample_stb = 1'b0;
    if (exp_base == 0) load_rel();
    for (int k = 0; k < 3; k++)
      e[k] = use_mic ? int'(m[k]) :
             ((exp_base < exp_rel[k]) ? 0 : wave(exp_base - exp_rel[k]));
    chk(out_valid === 1'b1, "R6 out_valid after strobe", int'(out_valid), 1);
    chk(int'(rel_a) == exp_rel[0], "R1 R2 R5 rel_a", int'(rel_a), exp_rel[0]);
    chk(int'(rel_b) == exp_rel[1], "R1 R2 R5 rel_b", int'(rel_b), exp_rel[1]);
    chk(int'(rel_c) == exp_rel[2], "R1 R2 R5 rel_c", int'(rel_c), exp_rel[2]);
    chk(int'(ch_a) == e[0], use_mic ? "R4 ch_a" : "R3 R6 ch_a", int'(ch_a), e[0]);
    chk(int'(ch_b) == e[1], use_mic ? "R4 ch_b" : "R3 R6 ch_b", int'(ch_b), e[1]);
    chk(int'(ch_c) == e[2], use_mic ? "R4 ch_c" : "R3 R6 ch_c", int'(ch_c), e[2]);
    exp_base = (exp_base + 1) % BUF;
  endtask

  task automatic run_beats(input int n);
    for (int i = 0; i < n; i++) beat_check();
  endtask

  task automatic full_buffer_at(input int x, input int y);
    set_coord(x, y);
    run_beats(((BUF - exp_base) % BUF) + BUF);
  endtask

  initial begin
    logic [7:0] ha, hb, hc;
    int bb;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    // R8 reset state
    chk(out_valid === 1'b0, "R8 out_valid in reset", int'(out_valid), 0);
    chk(rel_a == 0 && rel_b == 0 && rel_c == 0, "R8 rel in reset", int'(rel_a) + int'(rel_b) + int'(rel_c), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R8 out_valid after reset", int'(out_valid), 0);

    // directed corners: on a microphone, diagonal, extremes
    full_buffer_at(0, 0);
    full_buffer_at(16, 16);
    full_buffer_at(-32, -32);
    full_buffer_at(31, 31);
    full_buffer_at(-32, 31);
    full_buffer_at(16, 0);

    // R5: coordinate change mid-buffer keeps old delays until wrap
    run_beats(10);
    set_coord(-20, 25);
    run_beats(30);
    run_beats((BUF - exp_base) % BUF + 5);

    // constrained random coordinates
    for (int i = 0; i < 5; i++) begin
      int rx, ry;
      rx = int'($urandom % 64) - 32;
      ry = int'($urandom % 64) - 32;
      full_buffer_at(rx, ry);
    end

    // R7 stall: held outputs, strobes ignored
    set_coord(5, 9);
    run_beats((BUF - exp_base) % BUF + 3);
    repeat (2) @(negedge clk);
    out_ready = 1'b0;
    beat_check();
    ha = ch_a; hb = ch_b; hc = ch_c;
    bb = exp_base;
    sample_stb = 1'b1;
    repeat (3) @(negedge clk);
    sample_stb = 1'b0;
    chk(out_valid === 1'b1, "R7 valid held", int'(out_valid), 1);
    chk(ch_a == ha && ch_b == hb && ch_c == hc, "R7 data held", int'(ch_a), int'(ha));
    out_ready = 1'b1;
    repeat (2) @(negedge clk);
    chk(out_valid === 1'b0, "R6 valid drops once taken", int'(out_valid), 0);
    chk(exp_base == bb, "R7 model position", exp_base, bb);
    run_beats(4);

    // R4 microphone mode
    use_mic = 1'b1;
    run_beats(20);
    use_mic = 1'b0;
    run_beats(5);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule